// File: doc/BRIEF.md
# Segmented Transmit Bus Framing Monitor

This block watches a transmit bus that carries several fixed-width segments per clock. Each segment has its own enable, start and end markers, an error marker, a channel number and an empty-byte count. The monitor never drives the bus. It follows packet framing per channel and reports the first framing violation it sees. It also presents, for every segment, the empty-byte count that a receiver would use once the error rule has been applied.

Each channel has a two-state machine. `CH_IDLE` means no packet is open and `CH_OPEN` means a packet has started and not yet ended. On an enabled segment the transitions are: an end marker leads to `CH_IDLE`; a start marker without an end leads to `CH_OPEN`; otherwise the state is kept. The segments of one cycle are evaluated one after another from segment 0 upward. Each segment sees the channel states as the lower segments left them, so interleaved packets on different channels are followed correctly.

A single reporting machine has two states. `MON_CLEAN` moves to `MON_FAULT` on the first cycle that contains a violation, and it captures the violation code and the segment index at that moment. `MON_FAULT` holds until reset. Channel tracking goes on while the reporter is in `MON_FAULT`.

Top module: `seg_frame_monitor`

## Requirements
- R1: After reset the violation flag, the code and the segment index are all 0, and every channel is in `CH_IDLE`.
- R2: A segment whose enable is low has no effect. It raises no violation, changes no channel state and gives an effective empty count of 0, whatever its other inputs are.
- R3: An enabled segment with start high on a channel in `CH_OPEN` is a duplicate-start violation, code 2'b01.
- R4: An enabled segment with start low on a channel in `CH_IDLE` is an orphan violation, code 2'b10. This holds whether or not its end marker is set.
- R5: A segment with start and end both high on an idle channel is a complete packet and leaves the channel in `CH_IDLE`.
- R6: Each channel is tracked independently, so segments of packets on different channels may be interleaved freely, within a cycle and across cycles, without a violation.
- R7: Within one cycle, segment i is evaluated before segment i+1. A start followed by middle and end segments of the same channel later in the same cycle is legal. An end on an idle channel in a lower segment, followed by a start in a higher segment, is an orphan violation at the lower segment.
- R8: The violation flag is sticky until reset. Code and segment index record the first violating cycle, and within that cycle the lowest violating segment. Later violations change neither.
- R9: The effective empty count of a segment, at bits [4s+3:4s], follows the same cycle's inputs. It is the input count when enable and end are high and error is low. It is {count[3],3'b000} when enable, end and error are all high. It is 0 otherwise.
- R10: A violation sampled at a clock edge shows on the flag right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_en | input | NSEG | Per-segment enable qualifier |
| seg_sop | input | NSEG | Per-segment packet start marker |
| seg_eop | input | NSEG | Per-segment packet end marker |
| seg_err | input | NSEG | Per-segment packet error marker (meaningful with end) |
| seg_chan | input | NSEG*CHW | Channel number per segment, segment s at [s*CHW +: CHW] |
| seg_mty | input | NSEG*MTYW | Empty-byte count per segment, segment s at [s*MTYW +: MTYW] |
| viol_flag | output | 1 | Sticky violation flag |
| viol_code | output | 2 | First violation: 01 duplicate start, 10 orphan segment |
| viol_seg | output | SEGW | Segment index of the first violation |
| eff_mty | output | NSEG*MTYW | Effective empty count per segment after the error rule |

## Verification
The bench builds the monitor with four segments and four channels. With only four channels, every channel can be crossed with every segment position for both the duplicate-start and the orphan rules. Every enable/end/error combination can also be swept against all sixteen empty-count values on each segment. Four segments leave room for cycles that hold a whole packet, interleave four channels at once, or hold two violations, so segment ordering and first-violation capture can be checked.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
    typedef enum logic {CH_IDLE = 1'b0, CH_OPEN = 1'b1} chan_st_e;
    typedef enum logic {MON_CLEAN = 1'b0, MON_FAULT = 1'b1} mon_st_e;
    typedef enum logic [1:0] {
        VC_NONE      = 2'b00,
        VC_DUP_START = 2'b01,
        VC_ORPHAN    = 2'b10
    } viol_code_e;
endpackage

// File: rtl/seg_mty_fix.sv
module seg_mty_fix #(
    parameter int MTYW = 4
) (
    input  logic            en,
    input  logic            eop,
    input  logic            err,
    input  logic [MTYW-1:0] mty_in,
    output logic [MTYW-1:0] mty_out
);
    // the error marker clears all but the top bit of the empty count
    always_comb begin
        mty_out = '0;
        if (en && eop) begin
            if (err) mty_out = {mty_in[MTYW-1], {(MTYW-1){1'b0}}};
            else     mty_out = mty_in;
        end
    end
endmodule

// File: rtl/seg_chan_tracker.sv
module seg_chan_tracker
    import segchk_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int NCHAN = 16,
    localparam int CHW  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSEG-1:0]     seg_en,
    input  logic [NSEG-1:0]     seg_sop,
    input  logic [NSEG-1:0]     seg_eop,
    input  logic [NSEG*CHW-1:0] seg_chan,
    output logic [NSEG-1:0]     viol_dup,
    output logic [NSEG-1:0]     viol_orph
);
    chan_st_e state_q [NCHAN];
    chan_st_e state_d [NCHAN];

    // state register: one two-state machine per channel
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCHAN; c++) begin
            if (!rst_n) state_q[c] <= CH_IDLE;
            else        state_q[c] <= state_d[c];
        end
    end

    // segments are walked in ascending order, each one sees the states left by the ones below it
    always_comb begin
        logic [CHW-1:0] ch;
        for (int c = 0; c < NCHAN; c++) state_d[c] = state_q[c];
        viol_dup  = '0;
        viol_orph = '0;
        for (int s = 0; s < NSEG; s++) begin
            ch = seg_chan[s*CHW +: CHW];
            if (seg_en[s]) begin
                unique case (state_d[ch])
                    CH_OPEN: viol_dup[s]  = seg_sop[s];
                    CH_IDLE: viol_orph[s] = !seg_sop[s];
                endcase
                if (seg_eop[s])      state_d[ch] = CH_IDLE;
                else if (seg_sop[s]) state_d[ch] = CH_OPEN;
            end
        end
    end

    // R3: start on segment 0 against an already open channel
    p_dup_seg0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en[0] && seg_sop[0] && state_q[seg_chan[CHW-1:0]] == CH_OPEN) |-> viol_dup[0]);

    // R5: an end on the last segment leaves that channel idle
    p_end_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en[NSEG-1] && seg_eop[NSEG-1])
        |=> state_q[$past(seg_chan[(NSEG-1)*CHW +: CHW])] == CH_IDLE);

    for (genvar s = 0; s < NSEG; s++) begin : g_quiet
        // R2: a disabled segment never violates
        p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !seg_en[s] |-> !(viol_dup[s] || viol_orph[s]));
    end
endmodule

// File: rtl/seg_viol_recorder.sv
module seg_viol_recorder
    import segchk_pkg::*;
#(
    parameter int NSEG  = 4,
    localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEG-1:0] viol_dup,
    input  logic [NSEG-1:0] viol_orph,
    output logic            viol_flag,
    output logic [1:0]      viol_code,
    output logic [SEGW-1:0] viol_seg
);
    mon_st_e    mon_q, mon_d;
    viol_code_e code_q, first_code;
    logic [SEGW-1:0] seg_q, first_seg;
    logic any_viol;

    // lowest violating segment wins
    always_comb begin
        any_viol   = |(viol_dup | viol_orph);
        first_code = VC_NONE;
        first_seg  = '0;
        for (int s = NSEG - 1; s >= 0; s--) begin
            if (viol_dup[s] || viol_orph[s]) begin
                first_code = viol_dup[s] ? VC_DUP_START : VC_ORPHAN;
                first_seg  = SEGW'(s);
            end
        end
    end

    always_comb begin
        mon_d = mon_q;
        unique case (mon_q)
            MON_CLEAN: if (any_viol) mon_d = MON_FAULT;
            MON_FAULT: mon_d = MON_FAULT;
        endcase
    end

    // state register with capture on the CLEAN->FAULT transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q  <= MON_CLEAN;
            code_q <= VC_NONE;
            seg_q  <= '0;
        end else begin
            mon_q <= mon_d;
            if (mon_q == MON_CLEAN && any_viol) begin
                code_q <= first_code;
                seg_q  <= first_seg;
            end
        end
    end

    // output process
    always_comb begin
        viol_flag = (mon_q == MON_FAULT);
        viol_code = code_q;
        viol_seg  = seg_q;
    end

    // R8: once raised, the report is frozen
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> (viol_flag && $stable(viol_code) && $stable(viol_seg)));
    // R8: a raised flag always carries a real code
    p_code_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |-> (viol_code == VC_DUP_START || viol_code == VC_ORPHAN));
    // R10: a violation in a clean cycle is visible after the edge
    p_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_flag && any_viol) |=> viol_flag);
endmodule

// File: rtl/seg_frame_monitor.sv
module seg_frame_monitor #(
    parameter int NSEG      = 4,
    parameter int NCHAN     = 16,
    parameter int SEG_BYTES = 16,
    localparam int CHW  = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int MTYW = $clog2(SEG_BYTES),
    localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSEG-1:0]      seg_en,
    input  logic [NSEG-1:0]      seg_sop,
    input  logic [NSEG-1:0]      seg_eop,
    input  logic [NSEG-1:0]      seg_err,
    input  logic [NSEG*CHW-1:0]  seg_chan,
    input  logic [NSEG*MTYW-1:0] seg_mty,
    output logic                 viol_flag,
    output logic [1:0]           viol_code,
    output logic [SEGW-1:0]      viol_seg,
    output logic [NSEG*MTYW-1:0] eff_mty
);
    logic [NSEG-1:0] viol_dup, viol_orph;

    seg_chan_tracker #(.NSEG(NSEG), .NCHAN(NCHAN)) u_track (
        .clk(clk), .rst_n(rst_n),
        .seg_en(seg_en), .seg_sop(seg_sop), .seg_eop(seg_eop), .seg_chan(seg_chan),
        .viol_dup(viol_dup), .viol_orph(viol_orph)
    );

    seg_viol_recorder #(.NSEG(NSEG)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .viol_dup(viol_dup), .viol_orph(viol_orph),
        .viol_flag(viol_flag), .viol_code(viol_code), .viol_seg(viol_seg)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_mty
        seg_mty_fix #(.MTYW(MTYW)) u_fix (
            .en(seg_en[s]), .eop(seg_eop[s]), .err(seg_err[s]),
            .mty_in(seg_mty[s*MTYW +: MTYW]), .mty_out(eff_mty[s*MTYW +: MTYW])
        );
        // R9: error on an end segment zeroes the low empty bits, keeps the top one
        p_err_mty_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_en[s] && seg_eop[s] && seg_err[s]) |->
            (eff_mty[s*MTYW +: MTYW-1] == '0 &&
             eff_mty[s*MTYW + MTYW-1] == seg_mty[s*MTYW + MTYW-1]));
        // R2: disabled segment gives empty count 0
        p_off_mty_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !seg_en[s] |-> eff_mty[s*MTYW +: MTYW] == '0);
    end
endmodule

// File: tb/seg_frame_monitor_test.sv
module seg_frame_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG  = 4;
    localparam int NCHAN = 4;
    localparam int CHW   = 2;
    localparam int MTYW  = 4;
    localparam int SEGW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSEG-1:0] en, sop, eop, err;
    logic [NSEG*CHW-1:0] chan;
    logic [NSEG*MTYW-1:0] mty;
    logic vflag;
    logic [1:0] vcode;
    logic [SEGW-1:0] vseg;
    logic [NSEG*MTYW-1:0] emty;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_frame_monitor #(.NSEG(NSEG), .NCHAN(NCHAN), .SEG_BYTES(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .seg_en(en), .seg_sop(sop), .seg_eop(eop), .seg_err(err),
        .seg_chan(chan), .seg_mty(mty),
        .viol_flag(vflag), .viol_code(vcode), .viol_seg(vseg), .eff_mty(emty)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        en = '0; sop = '0; eop = '0; err = '0; chan = '0; mty = '0;
    endtask

    task automatic put(int s, bit e, bit so, bit eo, int ch);
        en[s] = e; sop[s] = so; eop[s] = eo; chan[s*CHW +: CHW] = CHW'(ch);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic reset_dut();
        clr();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk_rep(string req, int f, int c, int s);
        chk({req, " flag"}, int'(vflag), f);
        chk({req, " code"}, int'(vcode), c);
        chk({req, " seg"}, int'(vseg), s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr();
        @(negedge clk);
        reset_dut();
        // R1: reset state
        chk_rep("R1", 0, 0, 0);
        // R1: all channels idle, so a continuation on any channel is orphan
        for (int c = 0; c < NCHAN; c++) begin
            reset_dut();
            put(0, 1, 0, 0, c); tick();
            chk_rep("R1 idle", 1, 2, 0);
        end

        // R2: disabled segments with junk never flag
        reset_dut();
        for (int k = 0; k < 8; k++) begin
            sop = NSEG'(k); eop = NSEG'(~k); err = '1; chan = NSEG*CHW'(k * 37); mty = '1;
            #1 chk("R2 mty", int'(emty), 0);
            tick();
            chk("R2 quiet", int'(vflag), 0);
        end
        // R2: disabled end does not close an open channel
        reset_dut();
        put(0, 1, 1, 0, 1); tick();
        put(1, 0, 0, 1, 1); tick();
        chk("R2 open kept", int'(vflag), 0);
        put(0, 1, 1, 0, 1); tick();
        chk_rep("R2 R3", 1, 1, 0);
        // R2: disabled start does not open a channel
        reset_dut();
        put(2, 0, 1, 0, 2); tick();
        put(1, 1, 0, 1, 2); tick();
        chk_rep("R2 idle kept", 1, 2, 1);

        // R3: duplicate start, every channel at every segment
        for (int c = 0; c < NCHAN; c++)
            for (int s = 0; s < NSEG; s++) begin
                reset_dut();
                put(0, 1, 1, 0, c); tick();
                put(s, 1, 1, 0, c); tick();
                chk_rep("R3", 1, 1, s);
            end

        // R4 and R10: orphan, with and without end
        for (int c = 0; c < NCHAN; c++)
            for (int s = 0; s < NSEG; s++)
                for (int e = 0; e < 2; e++) begin
                    reset_dut();
                    put(s, 1, 0, e[0], c);
                    #1 chk("R10 not early", int'(vflag), 0);
                    tick();
                    chk_rep("R4", 1, 2, s);
                end

        // R5: single-segment packets leave the channel idle
        for (int c = 0; c < NCHAN; c++) begin
            reset_dut();
            put(0, 1, 1, 1, c); tick();
            put(2, 1, 1, 0, c); tick();
            put(1, 1, 0, 1, c); tick();
            chk("R5 legal", int'(vflag), 0);
            put(3, 1, 1, 1, c); tick();
            put(1, 1, 0, 0, c); tick();
            chk_rep("R5 idle after", 1, 2, 1);
        end

        // R6: four channels interleaved
        reset_dut();
        put(0, 1, 1, 0, 0); put(1, 1, 1, 0, 1); put(2, 1, 1, 0, 2); put(3, 1, 1, 0, 3); tick();
        put(0, 1, 0, 0, 3); put(1, 1, 0, 0, 0); put(2, 1, 0, 1, 1); put(3, 1, 0, 0, 2); tick();
        put(0, 1, 0, 1, 0); put(1, 1, 0, 1, 2); put(2, 1, 0, 1, 3); put(3, 1, 1, 0, 1); tick();
        put(0, 1, 0, 0, 1); put(1, 1, 1, 0, 0); put(2, 1, 0, 1, 0); put(3, 1, 0, 1, 1); tick();
        chk("R6 interleave", int'(vflag), 0);

        // R7: whole packet ordered within a cycle is legal
        reset_dut();
        put(0, 1, 1, 0, 1); put(1, 1, 0, 0, 1); put(2, 1, 1, 1, 3); put(3, 1, 0, 1, 1); tick();
        chk("R7 ordered", int'(vflag), 0);
        // R7: end below start in the same cycle is an orphan at the lower segment
        reset_dut();
        put(1, 1, 0, 1, 2); put(2, 1, 1, 0, 2); tick();
        chk_rep("R7 reversed", 1, 2, 1);

        // R8: lowest segment wins, later violations ignored
        reset_dut();
        put(1, 1, 0, 0, 0); put(3, 1, 0, 0, 1); tick();
        chk_rep("R8 lowest", 1, 2, 1);
        put(0, 1, 0, 0, 2); tick();
        chk_rep("R8 sticky", 1, 2, 1);
        put(0, 1, 1, 1, 3); tick();
        chk_rep("R8 held", 1, 2, 1);
        reset_dut();
        put(0, 1, 1, 0, 0); tick();
        put(2, 1, 1, 0, 0); put(3, 1, 0, 0, 3); tick();
        chk_rep("R8 dup first", 1, 1, 2);

        // R9: effective empty count sweep
        reset_dut();
        for (int s = 0; s < NSEG; s++)
            for (int b = 0; b < 8; b++)
                for (int m = 0; m < 16; m++) begin
                    int exp;
                    clr();
                    en[s] = b[0]; eop[s] = b[1]; err[s] = b[2];
                    sop[s] = 1'b1; eop[s] = b[1];
                    mty[s*MTYW +: MTYW] = MTYW'(m);
                    if (b[0] && b[1]) exp = b[2] ? (m & 8) : m;
                    else exp = 0;
                    #1 chk("R9", int'(emty), exp << (s*MTYW));
                end
        clr();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule